// File: doc/BRIEF.md
# Early-Terminating Iterative Divider

A sequential integer divider for an execute pipeline. A single-cycle `start` pulse captures a dividend, a divisor and a flag that selects signed or unsigned operation. The divider computes one quotient bit per cycle. Its latency depends on the data because it first strips the leading zero bits from the dividend's magnitude. Only as many iterations run as there are significant dividend bits. Two fixed cycles are added: one to form the magnitudes and count leading zeros, and one to apply the sign correction.

`busy` is high for the whole operation. When it falls, `done` pulses for one cycle, and `quotient` and `remainder` carry the result. Both hold until the next accepted start. A start that arrives while the divider is working is dropped. Division by zero follows the normal schedule and returns a fixed pattern, so the surrounding pipeline never needs a special case for timing.

Top module: `div_et_core`

## Requirements
- R1: After reset, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: With `is_signed`=0, the operands are unsigned. The result is quotient = floor(dividend/divisor) and remainder = dividend − quotient·divisor.
- R3: When `start` is sampled at an edge while idle, `busy` is high for exactly WIDTH − CLZ(|dividend|) + 2 consecutive cycles, starting in the cycle after that edge. CLZ is the count of leading zero bits in the WIDTH-bit magnitude. `done` rises in the cycle in which `busy` falls, and the two are never high together.
- R4: A dividend magnitude with its top bit set gives the worst case of WIDTH + 2 busy cycles (34 for 32 bits).
- R5: A zero dividend with a nonzero divisor takes exactly 2 busy cycles and returns a zero quotient and a zero remainder.
- R6: With `is_signed`=1, both operands are two's complement. The quotient is rounded toward zero and is negated when the operand signs differ. The remainder carries the dividend's sign.
- R7: For a signed negative dividend, the latency of R3 is set by the dividend's magnitude, not by its raw bit pattern.
- R8: A zero divisor, signed or unsigned, returns an all-ones quotient and the raw dividend as the remainder, on the R3 schedule.
- R9: A `start` while `busy` is high is ignored. The running operation keeps its latency and result.
- R10: `done` is high for exactly one cycle. `quotient` and `remainder` hold their values until the next operation completes.
- R11: The signed most-negative dividend divided by −1 returns the most-negative value as the quotient and zero as the remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when sampled high while idle |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend, captured with `start` |
| divisor | input | WIDTH | Divisor, captured with `start` |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| quotient | output | WIDTH | Result quotient, held after `done` |
| remainder | output | WIDTH | Result remainder, held after `done` |

## Verification
The hardest case to reach from the ports is a second `start` that lands in the middle of the iterations, after the operands are captured and before the sign correction. The directed task injects a start with different operands at a chosen busy cycle. It then checks that both the busy length and the result still match the first operation. Latency is checked over many dividend magnitudes, including signed negative ones whose raw pattern has every top bit set. A generated sweep right-shifts random dividends by varying amounts so that every iteration count occurs.

// File: rtl/div_et_pkg.sv
package div_et_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } div_state_e;

endpackage

// File: rtl/div_et_prep.sv
module div_et_prep #(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] a_raw,
  input  logic [WIDTH-1:0] b_raw,
  input  logic             signed_op,
  output logic [WIDTH-1:0] a_mag,
  output logic [WIDTH-1:0] b_mag,
  output logic [CW-1:0]    a_clz,
  output logic [CW-1:0]    iter_len
);

  function automatic logic [WIDTH-1:0] f_mag(input logic [WIDTH-1:0] v, input logic sgn);
    return (sgn && v[WIDTH-1]) ? (~v + WIDTH'(1)) : v;
  endfunction

  function automatic logic [CW-1:0] f_clz(input logic [WIDTH-1:0] v);
    logic [CW-1:0] n;
    logic          seen;
    n    = '0;
    seen = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      else if (!seen) n = n + CW'(1);
    end
    return n;
  endfunction

  always_comb begin
    a_mag    = f_mag(a_raw, signed_op);
    b_mag    = f_mag(b_raw, signed_op);
    a_clz    = f_clz(a_mag);
    iter_len = CW'(WIDTH) - a_clz;
  end

endmodule

// File: rtl/div_et_step.sv
module div_et_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_in,
  input  logic [WIDTH-1:0] quo_in,
  input  logic [WIDTH-1:0] dvs,
  output logic [WIDTH-1:0] rem_out,
  output logic [WIDTH-1:0] quo_out
);

  logic [WIDTH:0] trial;
  logic [WIDTH:0] diff;
  logic           fits;

  always_comb begin
    trial   = {rem_in, quo_in[WIDTH-1]};
    diff    = trial - {1'b0, dvs};
    fits    = (trial >= {1'b0, dvs});
    rem_out = fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
    quo_out = {quo_in[WIDTH-2:0], fits};
  end

endmodule

// File: rtl/div_et_ctrl.sv
module div_et_ctrl
  import div_et_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] iter_len,
  output div_state_e    state,
  output logic          accept,
  output logic          load,
  output logic          step_en,
  output logic          fix
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_SETUP;
        ST_SETUP: begin
          cnt   <= iter_len;
          state <= (iter_len == '0) ? ST_FIX : ST_ITER;
        end
        ST_ITER: begin
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) state <= ST_FIX;
        end
        ST_FIX:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    accept  = (state == ST_IDLE) && start;
    load    = (state == ST_SETUP);
    step_en = (state == ST_ITER);
    fix     = (state == ST_FIX);
  end

  AST_ITER_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ITER) |-> (cnt != '0)); // R3

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && start) |=> (state != ST_SETUP)); // R9

endmodule

// File: rtl/div_et_core.sv
module div_et_core
  import div_et_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  div_state_e       state;
  logic             accept, load, step_en, fix;
  logic [WIDTH-1:0] a_raw, b_raw;
  logic             sgn_q;
  logic [WIDTH-1:0] a_mag, b_mag;
  logic [CW-1:0]    a_clz, iter_len;
  logic [WIDTH-1:0] rem_q, quo_q, bmag_q;
  logic [WIDTH-1:0] rem_nx, quo_nx;
  logic [WIDTH-1:0] q_out, r_out;
  logic             done_q;
  logic [CW:0]      occ_cnt, occ_exp;

  function automatic logic [WIDTH-1:0] f_fix_quo(
    input logic [WIDTH-1:0] qm, input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b, input logic sgn);
    if (b == '0) return '1;
    if (sgn && (a[WIDTH-1] ^ b[WIDTH-1])) return ~qm + WIDTH'(1);
    return qm;
  endfunction

  function automatic logic [WIDTH-1:0] f_fix_rem(
    input logic [WIDTH-1:0] rm, input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b, input logic sgn);
    if (b == '0) return a;
    if (sgn && a[WIDTH-1]) return ~rm + WIDTH'(1);
    return rm;
  endfunction

  div_et_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_len(iter_len),
    .state(state), .accept(accept), .load(load), .step_en(step_en), .fix(fix)
  );

  div_et_prep #(.WIDTH(WIDTH)) u_prep (
    .a_raw(a_raw), .b_raw(b_raw), .signed_op(sgn_q),
    .a_mag(a_mag), .b_mag(b_mag), .a_clz(a_clz), .iter_len(iter_len)
  );

  div_et_step #(.WIDTH(WIDTH)) u_step (
    .rem_in(rem_q), .quo_in(quo_q), .dvs(bmag_q),
    .rem_out(rem_nx), .quo_out(quo_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_raw  <= '0;
      b_raw  <= '0;
      sgn_q  <= 1'b0;
      rem_q  <= '0;
      quo_q  <= '0;
      bmag_q <= '0;
      q_out  <= '0;
      r_out  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fix;
      if (accept) begin
        a_raw <= dividend;
        b_raw <= divisor;
        sgn_q <= is_signed;
      end
      if (load) begin
        rem_q  <= '0;
        quo_q  <= a_mag << a_clz;
        bmag_q <= b_mag;
      end else if (step_en) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
      end
      if (fix) begin
        q_out <= f_fix_quo(quo_q, a_raw, b_raw, sgn_q);
        r_out <= f_fix_rem(rem_q, a_raw, b_raw, sgn_q);
      end
    end
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    done      = done_q;
    quotient  = q_out;
    remainder = r_out;
  end

  // occupancy bookkeeping for the latency assertion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_cnt <= '0;
      occ_exp <= '0;
    end else begin
      if (accept)    occ_cnt <= '0;
      else if (busy) occ_cnt <= occ_cnt + (CW+1)'(1);
      if (load)      occ_exp <= {1'b0, iter_len} + (CW+1)'(2);
    end
  end

  AST_OCCUPANCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (occ_cnt == occ_exp)); // R3

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && bmag_q != '0) |-> (rem_q < bmag_q)); // R2

  AST_ZERO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (load && a_mag == '0) |=> fix); // R5

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fix && b_raw == '0) |=> (quotient == '1 && remainder == $past(a_raw))); // R8

  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (a_raw == $past(a_raw) && b_raw == $past(b_raw))); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix) |=> $stable(quotient)); // R10

endmodule

// File: tb/test_div_et_core.sv
`timescale 1ns/1ps
module test_div_et_core;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] quotient, remainder;

  int total = 0;
  int bad = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #2 clk = ~clk;

  div_et_core #(.WIDTH(W)) i_div_et_core (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // expected quotient/remainder through wide magnitude arithmetic
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                       output logic [W-1:0] eq, output logic [W-1:0] er,
                       output int ecyc);
    logic [63:0] ma, mb, mq, mr;
    bit na, nb;
    na = s && a[W-1];
    nb = s && b[W-1];
    ma = na ? (64'd0 - {{32{a[W-1]}}, a}) : {32'd0, a};
    mb = nb ? (64'd0 - {{32{b[W-1]}}, b}) : {32'd0, b};
    ecyc = 2;
    for (int k = 0; k < W; k++) if (ma[k]) ecyc = k + 3;
    if (mb == 0) begin
      eq = '1;
      er = a;
    end else begin
      mq = ma / mb;
      mr = ma % mb;
      eq = (na ^ nb) ? W'(64'd0 - mq) : mq[W-1:0];
      er = na ? W'(64'd0 - mr) : mr[W-1:0];
    end
  endtask

  // one operation; inject >= 1 drives an extra start on that busy cycle
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                        input string req, input int inject);
    logic [W-1:0] eq, er;
    int ecyc, bcnt, guard;
    bit overlap;
    model(a, b, s, eq, er, ecyc);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b; is_signed = s;
    @(negedge clk);
    start = 1'b0;
    bcnt = 0; guard = 0; overlap = 0;
    while (!done && guard < 100) begin
      if (busy) bcnt++;
      if (busy && done) overlap = 1;
      if (bcnt == inject) begin
        start = 1'b1; dividend = ~a; divisor = b ^ 32'h5; is_signed = ~s;
      end
      @(negedge clk);
      start = 1'b0;
      guard++;
    end
    chk(done == 1'b1, req, "done seen", {63'd0, done}, 64'd1);
    chk(bcnt == ecyc && !busy && !overlap, req, "busy cycles", bcnt, ecyc);
    chk(quotient == eq, req, "quotient", quotient, eq);
    chk(remainder == er, req, "remainder", remainder, er);
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
    chk(quotient == '0 && remainder == '0, "R1", "result after reset",
        {quotient, remainder}, 0);
  endtask

  task automatic t_unsigned();
    run_op(32'd100, 32'd7, 0, "R2", -1);
    run_op(32'hFFFF_FFFF, 32'd3, 0, "R2", -1);
    run_op(32'd5, 32'd9, 0, "R2", -1);
    run_op(32'd1, 32'd1, 0, "R2", -1);
    run_op(32'h0001_0000, 32'h0000_0100, 0, "R3", -1);
  endtask

  task automatic t_worst();
    run_op(32'h8000_0000, 32'd1, 0, "R4", -1);
    run_op(32'hC000_0001, 32'hFFFF_FFFF, 0, "R4", -1);
  endtask

  task automatic t_zero();
    run_op(32'd0, 32'd13, 0, "R5", -1);
    run_op(32'd0, 32'hFFFF_FFF0, 1, "R5", -1);
  endtask

  task automatic t_signed();
    run_op(-32'sd7, 32'd2, 1, "R6", -1);
    run_op(32'd7, -32'sd2, 1, "R6", -1);
    run_op(-32'sd7, -32'sd2, 1, "R6", -1);
    run_op(32'd1000, 32'd33, 1, "R6", -1);
    run_op(-32'sd1, 32'd1, 1, "R7", -1);
    run_op(32'h8000_0000, 32'd3, 1, "R7", -1);
  endtask

  task automatic t_div_zero();
    run_op(32'd12345, 32'd0, 0, "R8", -1);
    run_op(-32'sd99, 32'd0, 1, "R8", -1);
  endtask

  task automatic t_overflow();
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, "R11", -1);
  endtask

  task automatic t_start_ignored();
    run_op(32'h0FFF_0000, 32'd17, 0, "R9", 3);
    run_op(-32'sd50000, 32'd7, 1, "R9", 1);
  endtask

  task automatic t_hold();
    logic [W-1:0] q0, r0;
    run_op(32'd77, 32'd5, 0, "R10", -1);
    q0 = quotient; r0 = remainder;
    @(negedge clk);
    chk(!done, "R10", "done one cycle", {63'd0, done}, 0);
    repeat (5) @(negedge clk);
    chk(quotient == q0 && remainder == r0, "R10", "result held",
        {quotient, remainder}, {q0, r0});
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = nxt_rand() >> (i % 33);
      b = nxt_rand() >> ((i * 7) % 31);
      run_op(a, b, bit'(i % 2), (i % 2) ? "R6" : "R2", -1);
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_worst();
    t_zero();
    t_signed();
    t_div_zero();
    t_overflow();
    t_start_ignored();
    t_hold();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule